// File: doc/BRIEF.md
# Cascaded Pulse Accumulator Counter

This block counts single-cycle event strobes in a 16-bit counter made of two 8-bit bytes. The low byte and the high byte have their own register addresses and can be accessed one at a time. When the chain enable bit is set, each strobe adds one to the 16-bit value, and the low byte carries into the high byte. When the chain enable bit is clear, the counter ignores strobes and keeps its value.

A host reaches the block through a small register port. A write completes in one cycle. Reads are combinational. A word access at the low-byte address covers both bytes in one cycle. Byte accesses reach one byte only, so a host that reads or writes the two halves in separate cycles can see a different value from one word access.

When the high byte wraps during a count, a sticky overflow flag is set. If the overflow interrupt is enabled, the flag raises an interrupt line. The host clears the flag by writing 1 to it.

Top module: `pulse_acc16`

## Requirements
- R1: After reset the count, both control bits, the overflow flag and `irq` are all 0.
- R2: Control register (addr 2): bit 0 is the chain enable and bit 1 is the overflow interrupt enable. With bit 0 set, a `pulse` with no count write in the same cycle adds 1 to the 16-bit count. The new value is visible after the next rising edge.
- R3: The low byte wraps from 0xFF to 0x00 on the same edge that the high byte goes up by one.
- R4: A count step from 0xFFFF to 0x0000 sets the overflow flag, which reads as bit 0 at addr 3.
- R5: Writing 1 to bit 0 at addr 3 clears the overflow flag, and writing 0 leaves it unchanged. If a clear and a new overflow fall in the same cycle, the flag stays set.
- R6: `irq` is 1 exactly when the overflow flag and the interrupt enable are both 1.
- R7: When the chain enable is 0, the count ignores `pulse` and holds its value.
- R8: A count write (addr 0 or addr 1) in the same cycle as a `pulse` stores the written value and suppresses the increment. A byte write leaves the other byte as it was. A count write never sets the overflow flag.
- R9: With `wordAcc`=1, addr 0 reads and writes the full 16-bit count {high,low} in one cycle. With `wordAcc`=0, addr 0 is the low byte and addr 1 is the high byte. Byte reads are zero-extended, and byte writes take `wrData[7:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pulse | input | 1 | One-cycle count strobe |
| wrEn | input | 1 | Register write strobe |
| wordAcc | input | 1 | 1 = 16-bit access at addr 0, 0 = byte access |
| addr | input | 2 | 0 low/word, 1 high, 2 control, 3 flag |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Combinational read data |
| irq | output | 1 | Overflow interrupt request |

## Verification
The hardest cases to reach from the ports are an overflow and a flag clear in the same cycle, and a count pulse that arrives together with a byte write at the moment a carry is due. A pulse sequence alone would take tens of thousands of cycles to get there. The bench instead loads values next to each boundary with word and byte writes, for example 0x00FF, 0xFFFE and 0xFFFF. It then applies the coincident pulse and write in the same cycle. A long pseudo-random run mixes pulses with writes to every address, and a behavioural model checks the count, the flag and `irq` after every edge.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
  typedef enum logic [1:0] {
    ADDR_LO   = 2'd0,
    ADDR_HI   = 2'd1,
    ADDR_CTRL = 2'd2,
    ADDR_FLAG = 2'd3
  } pacc_addr_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrLo;        // load low byte
    logic wrHi;        // load high byte
    logic hiFromUpper; // high byte source: upper half of write data
    logic countEn;     // step the counter this cycle
    logic clrOvf;      // clear overflow flag
  } pacc_stb_t;
endpackage

// File: rtl/pacc_dp.sv
module pacc_dp
  import pacc_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  pacc_stb_t        stb,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] cnt,
  output logic             ovfFlag
);
  logic [BYTE_W-1:0] loByte, hiByte, hiSrc;
  logic carry, ovfSet;

  always_comb begin
    hiSrc  = stb.hiFromUpper ? wrData[CNT_W-1:BYTE_W] : wrData[BYTE_W-1:0];
    carry  = stb.countEn && (loByte == {BYTE_W{1'b1}});
    ovfSet = carry && (hiByte == {BYTE_W{1'b1}});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loByte  <= '0;
      hiByte  <= '0;
      ovfFlag <= 1'b0;
    end else begin
      if (stb.wrLo)         loByte <= wrData[BYTE_W-1:0];
      else if (stb.countEn) loByte <= loByte + 1'b1;
      if (stb.wrHi)         hiByte <= hiSrc;
      else if (carry)       hiByte <= hiByte + 1'b1;
      if (ovfSet)           ovfFlag <= 1'b1;
      else if (stb.clrOvf)  ovfFlag <= 1'b0;
    end
  end

  assign cnt = {hiByte, loByte};

  // R3: carry lands on the same edge as the low byte wrap
  p_carry_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.countEn && cnt[BYTE_W-1:0] == {BYTE_W{1'b1}} && !stb.wrHi)
      |=> (cnt[BYTE_W-1:0] == '0) && (cnt[CNT_W-1:BYTE_W] == BYTE_W'($past(cnt[CNT_W-1:BYTE_W]) + 1'b1)));

  // R4: full wrap sets the flag
  p_ovf_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.countEn && cnt == {CNT_W{1'b1}}) |=> ovfFlag);

  // R5: clear without coincident overflow drops the flag
  p_ovf_clr_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrOvf && !(stb.countEn && cnt == {CNT_W{1'b1}})) |=> !ovfFlag);

  // R9: word load takes the full value in one cycle
  p_word_wr_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrLo && stb.wrHi && stb.hiFromUpper) |=> cnt == $past(wrData));
endmodule

// File: rtl/pacc_ctrl.sv
module pacc_ctrl
  import pacc_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pulse,
  input  logic             wrEn,
  input  logic             wordAcc,
  input  logic [1:0]       addr,
  input  logic [1:0]       ctlBits,
  input  logic [CNT_W-1:0] cnt,
  input  logic             ovfFlag,
  output pacc_stb_t        stb,
  output logic [CNT_W-1:0] rdData,
  output logic             irq
);
  pacc_addr_e a;
  logic chainEn, ovfIe, cntWrite;

  always_comb begin
    a        = pacc_addr_e'(addr);
    cntWrite = wrEn && (a == ADDR_LO || a == ADDR_HI);
    stb.wrLo        = wrEn && (a == ADDR_LO);
    stb.wrHi        = wrEn && ((a == ADDR_LO && wordAcc) || a == ADDR_HI);
    stb.hiFromUpper = (a == ADDR_LO);
    stb.countEn     = pulse && chainEn && !cntWrite;
    stb.clrOvf      = wrEn && (a == ADDR_FLAG) && ctlBits[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chainEn <= 1'b0;
      ovfIe   <= 1'b0;
    end else if (wrEn && a == ADDR_CTRL) begin
      chainEn <= ctlBits[0];
      ovfIe   <= ctlBits[1];
    end
  end

  always_comb begin
    rdData = '0;
    unique case (a)
      ADDR_LO:   rdData = wordAcc ? cnt : {{BYTE_W{1'b0}}, cnt[BYTE_W-1:0]};
      ADDR_HI:   rdData = {{BYTE_W{1'b0}}, cnt[CNT_W-1:BYTE_W]};
      ADDR_CTRL: rdData = {{(CNT_W-2){1'b0}}, ovfIe, chainEn};
      ADDR_FLAG: rdData = {{(CNT_W-1){1'b0}}, ovfFlag};
    endcase
  end

  assign irq = ovfFlag && ovfIe;

  // R7: no chain enable and no count write -> value holds
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!chainEn && !cntWrite) |=> $stable(cnt));

  // R6: request only with the flag raised
  p_irq_r6: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ovfFlag);

  // R8: high byte write with a pulse leaves low byte untouched
  p_write_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && a == ADDR_HI && pulse) |=> cnt[BYTE_W-1:0] == $past(cnt[BYTE_W-1:0]));
endmodule

// File: rtl/pulse_acc16.sv
module pulse_acc16
  import pacc_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pulse,
  input  logic             wrEn,
  input  logic             wordAcc,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] rdData,
  output logic             irq
);
  pacc_stb_t        stb;
  logic [CNT_W-1:0] cnt;
  logic             ovfFlag;

  pacc_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .pulse(pulse), .wrEn(wrEn), .wordAcc(wordAcc),
    .addr(addr), .ctlBits(wrData[1:0]), .cnt(cnt), .ovfFlag(ovfFlag),
    .stb(stb), .rdData(rdData), .irq(irq)
  );

  pacc_dp #(.BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .cnt(cnt), .ovfFlag(ovfFlag)
  );
endmodule

// File: tb/pulse_acc16_tb.sv
module pulse_acc16_tb;
  logic clk = 0, rstN = 0, pulse = 0, wrEn = 0, wordAcc = 0;
  logic [1:0]  addr = 0;
  logic [15:0] wrData = 0;
  logic [15:0] rdData;
  logic        irq;

  int errors = 0, checks = 0;
  int mCnt = 0, mEn = 0, mIe = 0, mFlag = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pulse_acc16 u_dut (.clk(clk), .rstN(rstN), .pulse(pulse), .wrEn(wrEn),
    .wordAcc(wordAcc), .addr(addr), .wrData(wrData), .rdData(rdData), .irq(irq));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic rdchk(input int a, input bit w, input int exp, input string tag);
    wrEn = 0; pulse = 0; addr = 2'(a); wordAcc = w;
    #1 chk(tag, int'(rdData), exp);
  endtask

  // compare model with DUT through its ports
  task automatic cmpAll(input string tag);
    rdchk(0, 1, mCnt, tag);
    rdchk(3, 0, mFlag, "R4/R5 flag");
    chk("R6 irq", int'(irq), (mFlag != 0 && mIe != 0) ? 1 : 0);
  endtask

  // one clock with given stimulus; model stepped from pre-edge state
  task automatic cyc(input bit p, input bit we, input bit w, input int a,
                     input int d, input string tag);
    bit setF;
    setF = 0;
    pulse = p; wrEn = we; wordAcc = w; addr = 2'(a); wrData = 16'(d);
    if (we && a == 0 && w)      mCnt = d & 16'hFFFF;
    else if (we && a == 0)      mCnt = (mCnt & 16'hFF00) | (d & 8'hFF);
    else if (we && a == 1)      mCnt = (mCnt & 8'hFF) | ((d & 8'hFF) << 8);
    else if (p && mEn != 0) begin
      if (mCnt == 16'hFFFF) begin mCnt = 0; setF = 1; end
      else mCnt = mCnt + 1;
    end
    if (setF) mFlag = 1;
    else if (we && a == 3 && d[0]) mFlag = 0;
    if (we && a == 2) begin mEn = d & 1; mIe = (d >> 1) & 1; end
    @(posedge clk); #1;
    wrEn = 0; pulse = 0;
    cmpAll(tag);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1 reset state
    rdchk(0, 1, 0, "R1 count");
    rdchk(2, 0, 0, "R1 ctrl");
    rdchk(3, 0, 0, "R1 flag");
    chk("R1 irq", int'(irq), 0);
    // R7 chain disabled: pulses ignored
    repeat (4) cyc(1, 0, 0, 0, 0, "R7 hold");
    rdchk(0, 1, 0, "R7 still zero");
    // R2 enable and count
    cyc(0, 1, 0, 2, 1, "R2 enable");
    repeat (5) cyc(1, 0, 0, 0, 0, "R2 step");
    rdchk(0, 1, 5, "R2 five pulses");
    // R3 carry
    cyc(0, 1, 1, 0, 16'h00FE, "R9 word write");
    cyc(1, 0, 0, 0, 0, "R3 to FF");
    cyc(1, 0, 0, 0, 0, "R3 carry");
    rdchk(1, 0, 16'h0001, "R3 high byte");
    rdchk(0, 0, 16'h0000, "R9 low byte zero-extended");
    // R4/R6 overflow
    cyc(0, 1, 0, 2, 3, "R6 enable irq");
    cyc(0, 1, 1, 0, 16'hFFFE, "R9 word write");
    cyc(1, 0, 0, 0, 0, "R4 FFFF");
    cyc(1, 0, 0, 0, 0, "R4 wrap");
    rdchk(3, 0, 1, "R4 flag set");
    chk("R6 irq high", int'(irq), 1);
    // R5 write 0 no effect, write 1 clears
    cyc(0, 1, 0, 3, 0, "R5 write zero");
    rdchk(3, 0, 1, "R5 flag kept");
    cyc(0, 1, 0, 3, 1, "R5 clear");
    rdchk(3, 0, 0, "R5 flag cleared");
    chk("R6 irq low", int'(irq), 0);
    // R5 coincident overflow and clear: set wins
    cyc(0, 1, 1, 0, 16'hFFFF, "R9 load");
    cyc(1, 1, 0, 3, 1, "R5 set beats clear");
    rdchk(3, 0, 1, "R5 flag set wins");
    // R8 write priority
    cyc(0, 1, 0, 3, 1, "R5 clear");
    cyc(1, 1, 1, 0, 16'h1234, "R8 word write with pulse");
    rdchk(0, 1, 16'h1234, "R8 word value");
    cyc(1, 1, 0, 0, 16'h00FF, "R8 low write with pulse");
    rdchk(0, 1, 16'h12FF, "R8 high kept");
    cyc(1, 1, 0, 1, 16'h00AB, "R8 high write with pulse");
    rdchk(0, 1, 16'hABFF, "R8 low kept");
    cyc(0, 1, 1, 0, 16'hFF00, "R8 load");
    cyc(0, 1, 0, 1, 16'h0000, "R8 wrap by write");
    rdchk(3, 0, 0, "R8 no flag from write");
    // R7 disable with count nonzero
    cyc(0, 1, 0, 2, 0, "R7 disable");
    repeat (3) cyc(1, 0, 0, 0, 0, "R7 hold");
    rdchk(0, 1, 16'h0000, "R7 held");
    // mixed pseudo-random run
    cyc(0, 1, 0, 2, 3, "R2 enable");
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (i % 50 == 0)
        cyc(0, 1, 1, 0, 16'hFFF0 | (lfsr & 15), "R9 near wrap");
      else if (lfsr[4:2] == 0)
        cyc(lfsr[0], 1, lfsr[7], int'(lfsr[6:5]), int'(lfsr ^ 16'h5A03), "R8 mixed");
      else
        cyc(lfsr[0] | lfsr[1], 0, 0, 0, 0, "R2 mixed");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule